// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is the device end of a serial memory link that uses four pins: a select, a serial clock, a serial input and a serial output with its own drive enable. The host raises select and clocks in a start marker, a two-bit operation code and an address. The block then reads out words, programs a word, erases a word, fills the whole array, or opens or closes the programming lock. The storage is a register array organized as 8-bit words (512 of them, 9 address bits) or as 16-bit words (256 of them, 8 address bits). A parameter chooses between the two.

All pins are sampled in the system clock domain, and a rising serial clock is detected from one clock sample to the next. Programming runs as a self-timed cycle that lasts a set number of system clocks. While that cycle runs, the host can lower select and raise it again to watch the serial output, which reads 0 while busy and 1 once ready. The link has no valid/ready back-pressure. The host paces every transfer with the serial clock, and a read streams words for as long as select stays high.

Top module: `eep3w_slave`

## Requirements
- R1: After reset the serial output is not driven, programming is locked, and every word reads back as all ones.
- R2: An instruction begins at the first 1 sampled on `ser_in` at a rising `ser_clk` after `chip_sel` rises, so leading zeros are skipped. The next two bits are the operation code, followed by the address MSB first (9 bits when WORD_W=8, 8 bits when WORD_W=16). For operation code 00, the two top address bits pick the instruction and the remaining address bits are clocked in but have no effect.
- R3: Read is operation code 10. At the rising `ser_clk` that samples the last address bit, the output is enabled and carries a single 0. Each later rising `ser_clk` presents the next data bit, MSB first.
- R4: While select stays high, after the last bit of a word the next rising `ser_clk` gives the MSB of the word at the next address, with no 0 in between. The address wraps from the last word to word 0.
- R5: Operation code 00 with top address bits 11 sets the programming lock open, and 00 with top bits 00 closes it. While the lock is closed, write, erase, erase-all and write-all leave the array unchanged and start no busy period.
- R6: Write is operation code 01. WORD_W data bits follow the address MSB first, and after the cycle the addressed word equals that data.
- R7: Erase is operation code 11 and sets the addressed word to all ones. Operation code 00 with top bits 10 sets every word to all ones. Operation code 00 with top bits 01 takes WORD_W data bits and stores them in every word.
- R8: A program cycle starts one clock after its last bit is accepted and lasts PROG_CYCLES clocks. The array changes only at the end of the cycle.
- R9: If `chip_sel` rises while a cycle runs, the output is driven until select falls. It reads 0 while busy and 1 once done. Bits clocked in during that window are ignored.
- R10: A low `chip_sel` abandons any partial instruction or read and releases the output from the next clock. The next instruction after that is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Select; high frames an instruction |
| ser_clk | input | 1 | Serial clock; rising edges sample input and advance output |
| ser_in | input | 1 | Serial instruction, address and data input |
| ser_out | output | 1 | Serial read data, or ready/busy level |
| ser_out_en | output | 1 | High when `ser_out` is driven |

## Verification
The bench builds the block with WORD_W=8, which gives the 9-bit address, and PROG_CYCLES=40. The wide address makes the wrap from word 511 to word 0 reachable. It also lets the special instructions carry nonzero filler bits below the two select bits. The short cycle lets the bench watch the busy level turn to ready within a single status window, and lets it clock a complete write into the block while busy to show that the write is dropped. The 16-bit organization is covered only through elaboration with default parameters.

// File: rtl/eep3w_pkg.sv
`timescale 1ns/1ps
package eep3w_pkg;

  typedef enum logic [2:0] {
    K_READ,
    K_WRITE,
    K_ERASE,
    K_ERASE_ALL,
    K_WRITE_ALL,
    K_PROG_ON,
    K_PROG_OFF
  } cmd_kind_e;

  typedef enum logic [2:0] {
    RX_OFF,
    RX_START,
    RX_OPC,
    RX_ADDR,
    RX_DATA,
    RX_HOLD
  } rx_state_e;

  // opcode 00 is widened by the two top address bits
  function automatic cmd_kind_e decode_cmd(input logic [1:0] opc, input logic [1:0] sel);
    cmd_kind_e k;
    case (opc)
      2'b10:   k = K_READ;
      2'b01:   k = K_WRITE;
      2'b11:   k = K_ERASE;
      default: begin
        case (sel)
          2'b11:   k = K_PROG_ON;
          2'b10:   k = K_ERASE_ALL;
          2'b01:   k = K_WRITE_ALL;
          default: k = K_PROG_OFF;
        endcase
      end
    endcase
    return k;
  endfunction

  function automatic logic needs_data(input cmd_kind_e k);
    return (k == K_WRITE) || (k == K_WRITE_ALL);
  endfunction

  function automatic logic is_program(input cmd_kind_e k);
    return (k == K_WRITE) || (k == K_ERASE) || (k == K_ERASE_ALL) || (k == K_WRITE_ALL);
  endfunction

endpackage

// File: rtl/eep3w_rx.sv
`timescale 1ns/1ps
module eep3w_rx
  import eep3w_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_rise,
  input  logic              sk_rise,
  input  logic              din,
  input  logic              mute,
  output logic              cmd_valid,
  output cmd_kind_e         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data
);
  localparam int FIELD_MAX = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int CNT_W     = $clog2(FIELD_MAX + 1);

  rx_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         opc;
  logic [ADDR_W-1:0]  addr_nxt;
  cmd_kind_e          kind_nxt;

  assign addr_nxt = {cmd_addr[ADDR_W-2:0], din};
  assign kind_nxt = decode_cmd(opc, addr_nxt[ADDR_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_OFF;
      cnt       <= '0;
      opc       <= '0;
      cmd_valid <= 1'b0;
      cmd_kind  <= K_PROG_OFF;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (!sel) begin
        st <= RX_OFF;
      end else if (sel_rise) begin
        st <= RX_START;
      end else if (sk_rise && !mute) begin
        case (st)
          RX_START: begin
            if (din) begin
              st  <= RX_OPC;
              cnt <= '0;
            end
          end
          RX_OPC: begin
            opc <= {opc[0], din};
            if (cnt == CNT_W'(1)) begin
              st  <= RX_ADDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_ADDR: begin
            cmd_addr <= addr_nxt;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt      <= '0;
              cmd_kind <= kind_nxt;
              if (needs_data(kind_nxt)) begin
                st <= RX_DATA;
              end else begin
                st        <= RX_HOLD;
                cmd_valid <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            cmd_data <= {cmd_data[WORD_W-2:0], din};
            if (cnt == CNT_W'(WORD_W - 1)) begin
              st        <= RX_HOLD;
              cmd_valid <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  cmd_after_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> st == RX_HOLD);

endmodule

// File: rtl/eep3w_tx.sv
`timescale 1ns/1ps
module eep3w_tx #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sk_rise,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_oe,
  output logic              tx_do
);
  localparam int BIT_W = $clog2(WORD_W);

  logic             active;
  logic [BIT_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      tx_do   <= 1'b0;
      bit_idx <= '0;
      rd_addr <= '0;
    end else if (!sel) begin
      active <= 1'b0;
      tx_do  <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      tx_do   <= 1'b0;
      bit_idx <= BIT_W'(WORD_W - 1);
      rd_addr <= start_addr;
    end else if (active && sk_rise) begin
      tx_do <= rd_word[bit_idx];
      if (bit_idx == '0) begin
        bit_idx <= BIT_W'(WORD_W - 1);
        rd_addr <= rd_addr + 1'b1;
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end

  assign tx_oe = active;

  // R3
  dummy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !tx_do);

endmodule

// File: rtl/eep3w_prog.sv
`timescale 1ns/1ps
module eep3w_prog
  import eep3w_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int WORD_W      = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_rise,
  input  logic              cmd_valid,
  input  cmd_kind_e         cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              busy,
  output logic              stat_on,
  output logic              rd_start,
  output logic              arr_we,
  output logic              arr_fill,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [WORD_W-1:0] arr_data
);
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  logic              en_latch;
  logic [TMR_W-1:0]  tmr;
  cmd_kind_e         pend_kind;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;

  assign rd_start = cmd_valid && (cmd_kind == K_READ) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_latch  <= 1'b0;
      busy      <= 1'b0;
      tmr       <= '0;
      pend_kind <= K_PROG_OFF;
      pend_addr <= '0;
      pend_data <= '0;
      arr_we    <= 1'b0;
      arr_fill  <= 1'b0;
      arr_addr  <= '0;
      arr_data  <= '0;
    end else begin
      arr_we   <= 1'b0;
      arr_fill <= 1'b0;
      if (busy) begin
        if (tmr == TMR_W'(1)) begin
          busy     <= 1'b0;
          tmr      <= '0;
          arr_addr <= pend_addr;
          arr_data <= pend_data;
          arr_we   <= (pend_kind == K_WRITE) || (pend_kind == K_ERASE);
          arr_fill <= (pend_kind == K_WRITE_ALL) || (pend_kind == K_ERASE_ALL);
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (cmd_valid) begin
        if (cmd_kind == K_PROG_ON) begin
          en_latch <= 1'b1;
        end else if (cmd_kind == K_PROG_OFF) begin
          en_latch <= 1'b0;
        end else if (is_program(cmd_kind) && en_latch) begin
          busy      <= 1'b1;
          tmr       <= TMR_W'(PROG_CYCLES);
          pend_kind <= cmd_kind;
          pend_addr <= cmd_addr;
          pend_data <= needs_data(cmd_kind) ? cmd_data : '1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stat_on <= 1'b0;
    else if (!sel)             stat_on <= 1'b0;
    else if (sel_rise && busy) stat_on <= 1'b1;
  end

  // R5
  locked_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_program(cmd_kind) && !en_latch && !busy |=> !busy);

  // R8
  update_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || arr_fill) |-> !busy && $past(busy));

  // R9
  status_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_on && !sel |=> !stat_on);

endmodule

// File: rtl/eep3w_array.sv
`timescale 1ns/1ps
module eep3w_array #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              fill,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       word_q <= '1;
      else if (fill || (we && wr_addr == ADDR_W'(g)))   word_q <= wr_data;
    end
    assign words[g] = word_q;
  end

  assign rd_word = words[rd_addr];

endmodule

// File: rtl/eep3w_slave.sv
`timescale 1ns/1ps
module eep3w_slave
  import eep3w_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_out_en
);
  localparam int ADDR_W = (WORD_W == 8) ? 9 : 8;

  logic sel_q, sclk_q;
  logic sel_rise, sk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= chip_sel;
      sclk_q <= ser_clk;
    end
  end

  assign sel_rise = chip_sel & ~sel_q;
  assign sk_rise  = chip_sel & ser_clk & ~sclk_q;

  logic              cmd_valid;
  cmd_kind_e         cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [WORD_W-1:0] cmd_data;
  logic              busy, stat_on, rd_start;
  logic              arr_we, arr_fill;
  logic [ADDR_W-1:0] arr_addr, rd_addr;
  logic [WORD_W-1:0] arr_data, rd_word;
  logic              tx_oe, tx_do;

  eep3w_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel(chip_sel), .sel_rise(sel_rise),
    .sk_rise(sk_rise), .din(ser_in), .mute(stat_on),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  eep3w_prog #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .sel(chip_sel), .sel_rise(sel_rise),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy(busy), .stat_on(stat_on), .rd_start(rd_start),
    .arr_we(arr_we), .arr_fill(arr_fill), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  eep3w_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .fill(arr_fill),
    .wr_addr(arr_addr), .wr_data(arr_data), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  eep3w_tx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel(chip_sel), .sk_rise(sk_rise),
    .start(rd_start), .start_addr(cmd_addr), .rd_word(rd_word),
    .rd_addr(rd_addr), .tx_oe(tx_oe), .tx_do(tx_do)
  );

  assign ser_out_en = stat_on | tx_oe;
  assign ser_out    = stat_on ? ~busy : tx_do;

  // R10
  release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !ser_out_en);

  // R9
  mute_in_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_on |-> !cmd_valid);

endmodule

// File: tb/test_eep3w_slave.sv
`timescale 1ns/1ps
module test_eep3w_slave;
  localparam int WW    = 8;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PC    = 40;
  localparam int MASK  = (1 << WW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
  logic ser_out, ser_out_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_chg = 0;
  bit exp_oe = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int model_mem [DEPTH];
  bit model_en = 1'b0;

  always #5 clk = ~clk;

  eep3w_slave #(.WORD_W(WW), .PROG_CYCLES(PC)) i_eep3w_slave (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the drive enable against the model
  always @(negedge clk) begin
    #1;
    cyc++;
    if (mon_on && !done && (cyc - last_chg) >= 3)
      check("R3/R9/R10 drive enable", int'(ser_out_en), int'(exp_oe));
  end

  task automatic bit_hi(input bit b, input bit mark);
    @(negedge clk);
    ser_in = b;
    ser_clk = 1'b1;
    if (mark) begin exp_oe = 1'b1; last_chg = cyc; end
    repeat (3) @(negedge clk);
  endtask

  task automatic bit_lo();
    @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    bit_hi(b, 1'b0);
    bit_lo();
  endtask

  task automatic sel_on(input bit drive);
    @(negedge clk);
    chip_sel = 1'b1;
    exp_oe = drive;
    last_chg = cyc;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk);
    chip_sel = 1'b0;
    ser_clk = 1'b0;
    exp_oe = 1'b0;
    last_chg = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_fields(input bit [1:0] op, input int addr, input int data,
                             input bit has_data, input int lz);
    repeat (lz) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(addr[i]);
    if (has_data) for (int i = WW - 1; i >= 0; i--) send_bit(data[i]);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    sel_on(1'b1);
    check({req, " R9 busy level"}, int'(ser_out), 0);
    while (ser_out == 1'b0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({req, " R8 cycle length"}, (n >= PC - 24 && n <= PC - 4) ? 1 : 0, 1);
    check({req, " R9 ready level"}, int'(ser_out), 1);
    sel_off();
  endtask

  task automatic prog(input bit [1:0] op, input int addr, input int data,
                      input int lz, input string req);
    int  sel = (addr >> (AW - 2)) & 3;
    bit  special = (op == 2'b00);
    bit  has_data = (op == 2'b01) || (special && sel == 1);
    bit  latch_op = special && (sel == 3 || sel == 0);
    sel_on(1'b0);
    send_fields(op, addr, data, has_data, lz);
    sel_off();
    if (latch_op) begin
      model_en = (sel == 3);
    end else if (model_en) begin
      if (op == 2'b01)      model_mem[addr] = data & MASK;
      else if (op == 2'b11) model_mem[addr] = MASK;
      else for (int k = 0; k < DEPTH; k++) model_mem[k] = (sel == 2) ? MASK : (data & MASK);
      wait_ready(req);
    end else begin
      sel_on(1'b0);
      check({req, " no busy while locked"}, int'(ser_out_en), 0);
      sel_off();
    end
  endtask

  task automatic read_run(input int addr, input int nwords, input string req);
    sel_on(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    for (int i = AW - 1; i > 0; i--) send_bit(addr[i]);
    bit_hi(addr[0], 1'b1);
    check({req, " R3 dummy enable"}, int'(ser_out_en), 1);
    check({req, " R3 dummy level"}, int'(ser_out), 0);
    bit_lo();
    for (int w = 0; w < nwords; w++) begin
      int v = 0;
      for (int b = 0; b < WW; b++) begin
        bit_hi(1'b0, 1'b0);
        v = (v << 1) | int'(ser_out);
        bit_lo();
      end
      check({req, " read word"}, v, model_mem[(addr + w) % DEPTH]);
    end
    sel_off();
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) model_mem[k] = MASK;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 output released after reset", int'(ser_out_en), 0);
    mon_on = 1'b1;

    read_run(5, 1, "R1");
    read_run(511, 1, "R1");

    prog(2'b01, 5, 'hA5, 0, "R5");
    read_run(5, 1, "R5");

    prog(2'b00, 'h1A5, 0, 2, "R2");

    prog(2'b01, 5, 'hA5, 0, "R6");
    read_run(5, 1, "R6");
    prog(2'b01, 6, 'h3C, 0, "R6");
    prog(2'b01, 511, 'h81, 0, "R6");
    prog(2'b01, 0, 'h7E, 0, "R6");
    read_run(4, 3, "R4");
    read_run(511, 2, "R4");

    // bits clocked during the status window are dropped
    sel_on(1'b0);
    send_fields(2'b01, 6, 'h00, 1'b1, 0);
    sel_off();
    model_mem[6] = 0;
    sel_on(1'b1);
    check("R9 busy level during window", int'(ser_out), 0);
    send_fields(2'b01, 7, 'h11, 1'b1, 0);
    check("R9 ready level after cycle", int'(ser_out), 1);
    check("R9 still driven", int'(ser_out_en), 1);
    sel_off();
    read_run(6, 2, "R9");

    // partial write abandoned by deselect
    sel_on(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    repeat (4) send_bit(1'b1);
    sel_off();
    check("R10 output released after abort", int'(ser_out_en), 0);
    read_run(6, 1, "R10");

    // read abandoned mid-word
    sel_on(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    for (int i = AW - 1; i > 0; i--) send_bit(5 >> i);
    bit_hi(1'b1, 1'b1);
    bit_lo();
    repeat (3) send_bit(1'b0);
    sel_off();
    check("R10 output released mid-read", int'(ser_out_en), 0);
    read_run(5, 1, "R10");

    prog(2'b11, 5, 0, 0, "R7");
    read_run(5, 1, "R7");

    prog(2'b00, 'h03F, 0, 0, "R5");
    prog(2'b11, 6, 0, 0, "R5");
    read_run(6, 1, "R5");

    prog(2'b00, 'h1A5, 0, 0, "R5");
    prog(2'b00, 'h0FF, 'h5A, 0, "R7");
    read_run(510, 3, "R7");
    prog(2'b00, 'h13C, 0, 0, "R7");
    read_run(100, 2, "R7");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule